// File: doc/BRIEF.md
# Outbound Mailbox Descriptor Queue Manager

This block runs the descriptor queue of an outbound mailbox message unit. Software builds 32-byte descriptors in a circular ring in memory. It points the block at the ring through the dequeue and enqueue pointer registers. It then announces each new descriptor by setting a self-clearing increment bit in the mode register. The ring holds a power-of-two number of entries and must be aligned to its own byte size. Wrap-around is therefore a masked add.

While the unit is enabled and the two pointers differ, the block reads the descriptor at the dequeue pointer one word at a time over a request/acknowledge memory port. It decodes the descriptor and holds the decoded fields (source address, snoop request, mailbox, destination ID, priority, transfer size) to a transmit engine until the engine reports done or error. A completion moves the dequeue pointer on by one slot. A fault records an error and stops the unit. Event bits in the status register are cleared by writing 1, and any of them pending drives the interrupt output.

Top module: `msgq_out`

## Requirements
- R1: After reset, mode, both pointers and snoop attribute read 0, status reads 0x01 (ring empty only) and irq_o is low.
- R2: Registers are selected by word index: 0 mode, 1 status, 2 dequeue pointer, 3 enqueue pointer, 4 snoop attribute; other indices read 0. In mode, bit 0 is enable, bit 1 is a self-clearing enqueue-increment that always reads 0, and bits 15:12 hold the ring size code log2(entries)-2; written codes above 9 (2048 entries) are stored as 9.
- R3: Each accepted increment advances the enqueue pointer by 32 bytes; from the last slot it wraps to the base of the ring, which is aligned to entries*32 bytes.
- R4: The ring is full when advancing the enqueue pointer would make it equal the dequeue pointer. An increment while full leaves the enqueue pointer unchanged and sets status bit 5 (overflow).
- R5: When the unit is enabled and the pointers differ, the block reads the eight descriptor words at dequeue pointer + 4*k, k = 0..7 in order, holding each request and its address until acknowledged.
- R6: Decoded fields: source address is word 1 with bits 2:0 cleared; snoop is word 1 bit 2 OR snoop attribute bit 2; mailbox is word 2 bits 1:0; destination ID is word 3 bits 17:2; priority is word 3 bits 28:27; transfer size is word 6.
- R7: tx_valid_o stays high with stable fields until tx_done_i or tx_err_i. On done the dequeue pointer advances 32 bytes with the same wrap, and status bit 1 (end of message) is set if word 3 bit 29 is 1.
- R8: tx_err_i during a transfer, or a transfer size that is not a nonzero power of two, sets status bit 7 (transfer error), clears the enable bit and leaves the dequeue pointer unchanged; a bad size never raises tx_valid_o.
- R9: Status bit 0 (empty), bit 4 (full) and bit 2 (busy) show live state. Bits 7, 5 and 1 are events cleared by writing 1; a new event in the same cycle wins over the clear.
- R10: irq_o is high exactly while any of status bits 7, 5 or 1 is set.
- R11: Clearing enable while a descriptor is in progress lets that descriptor complete, then no further descriptor is started.
- R12: Pointer register writes take effect only while enable is clear and the unit is idle; bits 4:0 of a written pointer are forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Byte address of requested word |
| mem_ack_i | input | 1 | Request accepted, data valid |
| mem_rdata_i | input | 32 | Descriptor word read data |
| tx_valid_o | output | 1 | Descriptor presented to transmit engine |
| tx_saddr_o | output | 32 | Payload source address |
| tx_snoop_o | output | 1 | Snoop request for payload reads |
| tx_mbox_o | output | 2 | Target mailbox |
| tx_dest_o | output | 16 | Destination ID |
| tx_prio_o | output | 2 | Message priority |
| tx_size_o | output | 32 | Transfer size in bytes |
| tx_done_i | input | 1 | Transmit engine finished the message |
| tx_err_i | input | 1 | Transmit engine reported an error |
| irq_o | output | 1 | Interrupt, any event bit pending |

## Verification
The bench fills a four-entry ring until it is full. A design that counted all four slots as usable would accept the extra increment, and one that moved the pointer on overflow would corrupt the ring. Wrap-around of both pointers is driven across the ring end; an unmasked add would walk the fetch address out of the ring. Error paths are hit both from the engine and from a non-power-of-two size. A design that advanced the dequeue pointer or kept the unit enabled after a fault would replay or skip descriptors, and one that sent a bad size would raise tx_valid_o. Disabling mid-descriptor and writing a pointer while enabled catch a design that aborts work or lets software move pointers under a running fetch.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int WORD_W = 32;

  localparam logic [2:0] REG_MODE  = 3'd0;
  localparam logic [2:0] REG_STAT  = 3'd1;
  localparam logic [2:0] REG_DEQ   = 3'd2;
  localparam logic [2:0] REG_ENQ   = 3'd3;
  localparam logic [2:0] REG_SNOOP = 3'd4;

  localparam int MODE_EN    = 0;
  localparam int MODE_INC   = 1;
  localparam int MODE_CODE  = 12;

  localparam int ST_TE    = 7;
  localparam int ST_QO    = 5;
  localparam int ST_FULL  = 4;
  localparam int ST_BUSY  = 2;
  localparam int ST_EOM   = 1;
  localparam int ST_EMPTY = 0;

  localparam int SNOOP_BIT = 2;

  localparam logic [2:0] DW_SRC  = 3'd1;
  localparam logic [2:0] DW_PORT = 3'd2;
  localparam logic [2:0] DW_ATTR = 3'd3;
  localparam logic [2:0] DW_SIZE = 3'd6;
  localparam logic [2:0] DW_LAST = 3'd7;

  localparam int ATTR_EOM     = 29;
  localparam int ATTR_PRIO_LO = 27;

  localparam int SLOT_SHIFT = 5;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_FETCH = 2'd1,
    FS_SEND  = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/msgq_ring.sv
module msgq_ring import msgq_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              deq_wr_i,
  input  logic              enq_wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              inc_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] deq_o,
  output logic [ADDR_W-1:0] enq_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int SH_W = $clog2(ADDR_W) + 1;
  localparam logic [SH_W-1:0] SLOT_BASE_SH = SH_W'(SLOT_SHIFT + 2);

  logic [ADDR_W-1:0] deq_q, enq_q;
  logic [ADDR_W-1:0] span_mask;
  logic [SH_W-1:0]   span_sh;

  assign span_sh   = SH_W'(code_i) + SLOT_BASE_SH;
  assign span_mask = ~({ADDR_W{1'b1}} << span_sh);

  function automatic logic [ADDR_W-1:0] step_slot(input logic [ADDR_W-1:0] p,
                                                   input logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] inc;
    inc = p + ADDR_W'(1 << SLOT_SHIFT);
    return (p & ~m) | (inc & m);
  endfunction

  logic [ADDR_W-1:0] enq_next, deq_next;
  assign enq_next = step_slot(enq_q, span_mask);
  assign deq_next = step_slot(deq_q, span_mask);

  assign empty_o = (enq_q == deq_q);
  assign full_o  = (enq_next == deq_q);
  assign ovf_o   = inc_i & full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deq_q <= '0;
      enq_q <= '0;
    end else begin
      if (deq_wr_i)   deq_q <= {wdata_i[ADDR_W-1:SLOT_SHIFT], SLOT_SHIFT'(0)};
      else if (adv_i) deq_q <= deq_next;
      if (enq_wr_i)   enq_q <= {wdata_i[ADDR_W-1:SLOT_SHIFT], SLOT_SHIFT'(0)};
      else if (inc_i && !full_o) enq_q <= enq_next;
    end
  end

  assign deq_o = deq_q;
  assign enq_o = enq_q;

  AST_OVF_HOLDS_ENQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && full_o && !enq_wr_i) |=> (enq_q == $past(enq_q))); // R4

  AST_ADV_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !deq_wr_i) |=> (((deq_q ^ $past(deq_q)) & ~$past(span_mask)) == '0)); // R3
endmodule

// File: rtl/msgq_fetch.sv
module msgq_fetch import msgq_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DEST_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              empty_i,
  input  logic [ADDR_W-1:0] deq_i,
  input  logic              snoop_cfg_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  output logic [ADDR_W-1:0] tx_saddr_o,
  output logic              tx_snoop_o,
  output logic [1:0]        tx_mbox_o,
  output logic [DEST_W-1:0] tx_dest_o,
  output logic [1:0]        tx_prio_o,
  output logic [WORD_W-1:0] tx_size_o,
  input  logic              tx_done_i,
  input  logic              tx_err_i,
  output logic              busy_o,
  output logic              cmpl_o,
  output logic              eom_o,
  output logic              err_o
);
  fetch_st_e         st_q;
  logic [2:0]        idx_q;
  logic [ADDR_W-1:0] src_q;
  logic [1:0]        port_q;
  logic [WORD_W-1:0] attr_q, size_q;

  logic take, last, size_ok;
  assign take    = (st_q == FS_FETCH) && mem_ack_i;
  assign last    = take && (idx_q == DW_LAST);
  assign size_ok = (size_q != '0) && ((size_q & (size_q - 1'b1)) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      idx_q  <= '0;
      src_q  <= '0;
      port_q <= '0;
      attr_q <= '0;
      size_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (en_i && !empty_i) st_q <= FS_FETCH;
        FS_FETCH: if (take) begin
          idx_q <= idx_q + 3'd1;
          unique case (idx_q)
            DW_SRC:  src_q  <= mem_rdata_i[ADDR_W-1:0];
            DW_PORT: port_q <= mem_rdata_i[1:0];
            DW_ATTR: attr_q <= mem_rdata_i;
            DW_SIZE: size_q <= mem_rdata_i;
            default: ;
          endcase
          if (last) st_q <= size_ok ? FS_SEND : FS_IDLE;
        end
        FS_SEND: if (tx_done_i || tx_err_i) st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == FS_FETCH);
  assign mem_addr_o = deq_i + ADDR_W'({idx_q, 2'b00});

  assign tx_valid_o = (st_q == FS_SEND);
  assign tx_saddr_o = {src_q[ADDR_W-1:3], 3'b000};
  assign tx_snoop_o = src_q[SNOOP_BIT] | snoop_cfg_i;
  assign tx_mbox_o  = port_q;
  assign tx_dest_o  = attr_q[DEST_W+1:2];
  assign tx_prio_o  = attr_q[ATTR_PRIO_LO+1:ATTR_PRIO_LO];
  assign tx_size_o  = size_q;

  assign busy_o = (st_q != FS_IDLE);
  assign cmpl_o = (st_q == FS_SEND) && tx_done_i && !tx_err_i;
  assign eom_o  = cmpl_o && attr_q[ATTR_EOM];
  assign err_o  = ((st_q == FS_SEND) && tx_err_i) || (last && !size_ok);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R5

  AST_TX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_done_i && !tx_err_i) |=> (tx_valid_o && $stable(tx_size_o)
      && $stable(tx_dest_o) && $stable(tx_saddr_o))); // R7
endmodule

// File: rtl/msgq_out.sv
module msgq_out import msgq_pkg::*; #(
  parameter int ADDR_W       = 32,
  parameter int DEST_W       = 16,
  parameter int MAX_RING_LOG = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  output logic [ADDR_W-1:0] tx_saddr_o,
  output logic              tx_snoop_o,
  output logic [1:0]        tx_mbox_o,
  output logic [DEST_W-1:0] tx_dest_o,
  output logic [1:0]        tx_prio_o,
  output logic [31:0]       tx_size_o,
  input  logic              tx_done_i,
  input  logic              tx_err_i,
  output logic              irq_o
);
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_RING_LOG - 2);

  logic              en_q, snoop_q, te_q, qo_q, eom_q;
  logic [CODE_W-1:0] code_q, code_wr;
  logic [ADDR_W-1:0] deq, enq;
  logic empty, full, ovf, busy, cmpl, eom_ev, err_ev;

  logic wr_mode, wr_stat, wr_snoop, ptr_ok, inc;
  assign wr_mode  = reg_we_i && (reg_addr_i == REG_MODE);
  assign wr_stat  = reg_we_i && (reg_addr_i == REG_STAT);
  assign wr_snoop = reg_we_i && (reg_addr_i == REG_SNOOP);
  assign ptr_ok   = !en_q && !busy;
  assign inc      = wr_mode && reg_wdata_i[MODE_INC];

  assign code_wr = (reg_wdata_i[MODE_CODE+CODE_W-1:MODE_CODE] > MAX_CODE)
                   ? MAX_CODE : reg_wdata_i[MODE_CODE+CODE_W-1:MODE_CODE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      code_q  <= '0;
      snoop_q <= 1'b0;
      te_q    <= 1'b0;
      qo_q    <= 1'b0;
      eom_q   <= 1'b0;
    end else begin
      if (wr_mode) begin
        en_q   <= reg_wdata_i[MODE_EN];
        code_q <= code_wr;
      end
      if (err_ev) en_q <= 1'b0;
      if (wr_snoop) snoop_q <= reg_wdata_i[SNOOP_BIT];
      if (wr_stat) begin
        te_q  <= te_q  & ~reg_wdata_i[ST_TE];
        qo_q  <= qo_q  & ~reg_wdata_i[ST_QO];
        eom_q <= eom_q & ~reg_wdata_i[ST_EOM];
      end
      if (err_ev) te_q  <= 1'b1;
      if (ovf)    qo_q  <= 1'b1;
      if (eom_ev) eom_q <= 1'b1;
    end
  end

  msgq_ring #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (code_q),
    .deq_wr_i (reg_we_i && (reg_addr_i == REG_DEQ) && ptr_ok),
    .enq_wr_i (reg_we_i && (reg_addr_i == REG_ENQ) && ptr_ok),
    .wdata_i  (reg_wdata_i[ADDR_W-1:0]),
    .inc_i    (inc),
    .adv_i    (cmpl),
    .deq_o    (deq),
    .enq_o    (enq),
    .empty_o  (empty),
    .full_o   (full),
    .ovf_o    (ovf)
  );

  msgq_fetch #(.ADDR_W(ADDR_W), .DEST_W(DEST_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .empty_i     (empty),
    .deq_i       (deq),
    .snoop_cfg_i (snoop_q),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .tx_valid_o  (tx_valid_o),
    .tx_saddr_o  (tx_saddr_o),
    .tx_snoop_o  (tx_snoop_o),
    .tx_mbox_o   (tx_mbox_o),
    .tx_dest_o   (tx_dest_o),
    .tx_prio_o   (tx_prio_o),
    .tx_size_o   (tx_size_o),
    .tx_done_i   (tx_done_i),
    .tx_err_i    (tx_err_i),
    .busy_o      (busy),
    .cmpl_o      (cmpl),
    .eom_o       (eom_ev),
    .err_o       (err_ev)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_MODE: begin
        reg_rdata_o[MODE_EN] = en_q;
        reg_rdata_o[MODE_CODE+CODE_W-1:MODE_CODE] = code_q;
      end
      REG_STAT: begin
        reg_rdata_o[ST_TE]    = te_q;
        reg_rdata_o[ST_QO]    = qo_q;
        reg_rdata_o[ST_FULL]  = full;
        reg_rdata_o[ST_BUSY]  = busy;
        reg_rdata_o[ST_EOM]   = eom_q;
        reg_rdata_o[ST_EMPTY] = empty;
      end
      REG_DEQ:   reg_rdata_o[ADDR_W-1:0] = deq;
      REG_ENQ:   reg_rdata_o[ADDR_W-1:0] = enq;
      REG_SNOOP: reg_rdata_o[SNOOP_BIT] = snoop_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o = te_q | qo_q | eom_q;

  AST_START_NEEDS_WORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(en_q) && !$past(empty))); // R5

  AST_PTR_WR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_addr_i == REG_ENQ) && en_q) |=> (enq == $past(enq))); // R12

  AST_ERR_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ev |=> !en_q); // R8

  AST_DEQ_HOLD_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ev |=> (deq == $past(deq))); // R8
endmodule

// File: tb/msgq_out_bench.sv
`timescale 1ns/1ps
module msgq_out_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        tx_valid_o;
  logic [31:0] tx_saddr_o;
  logic        tx_snoop_o;
  logic [1:0]  tx_mbox_o;
  logic [15:0] tx_dest_o;
  logic [1:0]  tx_prio_o;
  logic [31:0] tx_size_o;
  logic        tx_done_i = 1'b0;
  logic        tx_err_i = 1'b0;
  logic        irq_o;

  always #4 clk_i = ~clk_i;

  msgq_out u_msgq_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .tx_valid_o(tx_valid_o), .tx_saddr_o(tx_saddr_o), .tx_snoop_o(tx_snoop_o),
    .tx_mbox_o(tx_mbox_o), .tx_dest_o(tx_dest_o), .tx_prio_o(tx_prio_o),
    .tx_size_o(tx_size_o), .tx_done_i(tx_done_i), .tx_err_i(tx_err_i),
    .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  bit saw_txv = 0;
  bit err_arm = 0;

  logic [31:0] mem_w [0:1023];

  // reference model state
  bit          m_en, m_snoop, m_te, m_qo, m_eom;
  logic [3:0]  m_code;
  logic [31:0] m_deq, m_enq;
  int          m_ph, m_wi, m_sc;
  logic [31:0] m_w1, m_w2, m_w3, m_w6;

  function automatic logic [31:0] nxt(input logic [31:0] p, input logic [3:0] c);
    logic [31:0] m;
    m = (32'h1 << (int'(c) + 7)) - 32'h1;
    return (p & ~m) | ((p + 32'd32) & m);
  endfunction

  function automatic bit pow2(input logic [31:0] v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      3'd0: begin r[0] = m_en; r[15:12] = m_code; end
      3'd1: begin
        r[7] = m_te; r[5] = m_qo; r[4] = (nxt(m_enq, m_code) == m_deq);
        r[2] = (m_ph != 0); r[1] = m_eom; r[0] = (m_enq == m_deq);
      end
      3'd2: r = m_deq;
      3'd3: r = m_enq;
      3'd4: r[2] = m_snoop;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic m_reset();
    m_en = 0; m_snoop = 0; m_te = 0; m_qo = 0; m_eom = 0; m_code = '0;
    m_deq = '0; m_enq = '0; m_ph = 0; m_wi = 0; m_sc = 0;
    m_w1 = '0; m_w2 = '0; m_w3 = '0; m_w6 = '0;
  endtask

  task automatic m_tick();
    bit full, last, cmpl, terr, errp, wm, ws, wp;
    logic [31:0] nd, ne;
    logic [3:0] c;
    full = (nxt(m_enq, m_code) == m_deq);
    last = (m_ph == 1) && mem_ack_i && (m_wi == 7);
    cmpl = (m_ph == 2) && tx_done_i && !tx_err_i;
    terr = (m_ph == 2) && tx_err_i;
    errp = terr || (last && !pow2(m_w6));
    wm = reg_we_i && reg_addr_i == 3'd0;
    ws = reg_we_i && reg_addr_i == 3'd1;
    wp = (!m_en) && (m_ph == 0);
    nd = m_deq; ne = m_enq;
    if (reg_we_i && reg_addr_i == 3'd2 && wp) nd = {reg_wdata_i[31:5], 5'b0};
    else if (cmpl) nd = nxt(m_deq, m_code);
    if (reg_we_i && reg_addr_i == 3'd3 && wp) ne = {reg_wdata_i[31:5], 5'b0};
    else if (wm && reg_wdata_i[1] && !full) ne = nxt(m_enq, m_code);
    m_te  = (m_te  && !(ws && reg_wdata_i[7])) || errp;
    m_qo  = (m_qo  && !(ws && reg_wdata_i[5])) || (wm && reg_wdata_i[1] && full);
    m_eom = (m_eom && !(ws && reg_wdata_i[1])) || (cmpl && m_w3[29]);
    case (m_ph)
      0: if (m_en && m_enq != m_deq) m_ph = 1;
      1: if (mem_ack_i) begin
           case (m_wi)
             1: m_w1 = mem_rdata_i;
             2: m_w2 = mem_rdata_i;
             3: m_w3 = mem_rdata_i;
             6: m_w6 = mem_rdata_i;
             default: ;
           endcase
           if (m_wi == 7) begin m_ph = pow2(m_w6) ? 2 : 0; m_sc = 0; end
           m_wi = (m_wi + 1) % 8;
         end
      default: begin
        if (tx_done_i || tx_err_i) m_ph = 0;
        else m_sc++;
      end
    endcase
    if (terr) err_arm = 0;
    if (wm) begin
      c = reg_wdata_i[15:12];
      m_code = (c > 4'd9) ? 4'd9 : c;
      m_en = reg_wdata_i[0];
    end
    if (errp) m_en = 0;
    if (reg_we_i && reg_addr_i == 3'd4) m_snoop = reg_wdata_i[2];
    m_deq = nd; m_enq = ne;
  endtask

  task automatic step();
    string rt;
    mem_ack_i   = (m_ph == 1) && ((cyc % 3) != 1);
    mem_rdata_i = mem_w[((m_deq + 32'(4 * m_wi)) >> 2) & 32'd1023];
    tx_done_i   = (m_ph == 2) && (m_sc >= 2) && !err_arm;
    tx_err_i    = (m_ph == 2) && (m_sc >= 2) && err_arm;
    #1;
    if (tx_valid_o) saw_txv = 1;
    chk({31'b0, mem_req_o}, {31'b0, (m_ph == 1)}, "R5 mem_req");
    chk(mem_addr_o, m_deq + 32'(4 * m_wi), "R5 mem_addr");
    chk({31'b0, tx_valid_o}, {31'b0, (m_ph == 2)}, "R7 tx_valid");
    chk(tx_saddr_o, {m_w1[31:3], 3'b0}, "R6 saddr");
    chk({31'b0, tx_snoop_o}, {31'b0, (m_w1[2] | m_snoop)}, "R6 snoop");
    chk({30'b0, tx_mbox_o}, {30'b0, m_w2[1:0]}, "R6 mbox");
    chk({16'b0, tx_dest_o}, {16'b0, m_w3[17:2]}, "R6 dest");
    chk({30'b0, tx_prio_o}, {30'b0, m_w3[28:27]}, "R6 prio");
    chk(tx_size_o, m_w6, "R6 size");
    chk({31'b0, irq_o}, {31'b0, (m_te | m_qo | m_eom)}, "R10 irq");
    case (reg_addr_i)
      3'd0: rt = "R2 mode";
      3'd1: rt = "R9 status";
      3'd2: rt = "R7 deq";
      3'd3: rt = "R3 enq";
      default: rt = "R2 reg";
    endcase
    chk(reg_rdata_o, m_rd(reg_addr_i), rt);
    @(posedge clk_i);
    m_tick();
    cyc++;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o, exp, tag);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 600; i++) begin
      step();
      if (m_ph == 0 && (!m_en || m_enq == m_deq)) return;
    end
    chk(32'd0, 32'd1, "R5 queue drain watchdog");
  endtask

  task automatic put_desc(input int slot, input bit eom, input logic [31:0] size);
    int b;
    b = slot * 8;
    for (int k = 0; k < 8; k++) mem_w[b + k] = 32'hDEAD_0000 + 32'(b + k);
    mem_w[b + 1] = 32'h8000_0000 + 32'(slot * 32'h100) + ((slot == 0) ? 32'h4 : 32'h0);
    mem_w[b + 2] = 32'(slot) | 32'hFFF0;
    mem_w[b + 3] = (32'(eom) << 29) | (32'h1 << 27) | (32'(16'h1230 + slot) << 2);
    mem_w[b + 6] = size;
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem_w[i] = '0;
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    rd(3'd0, 32'h0, "R1 mode after reset");
    rd(3'd1, 32'h1, "R1 status after reset");
    rd(3'd2, 32'h0, "R1 deq after reset");
    rd(3'd4, 32'h0, "R1 snoop after reset");
    chk({31'b0, irq_o}, 32'h0, "R1 irq after reset");

    for (int s = 0; s < 4; s++) put_desc(s, (s != 2), 32'd64 << s);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h101F);
    rd(3'd2, 32'h1000, "R12 low bits forced");
    wr(3'd3, 32'h1000);
    rd(3'd1, 32'h1, "R9 empty ring");

    repeat (3) wr(3'd0, 32'h2);
    rd(3'd3, 32'h1060, "R3 enq after three increments");
    rd(3'd1, 32'h10, "R4 full with three of four");
    rd(3'd0, 32'h0, "R2 increment bit reads zero");
    wr(3'd0, 32'h2);
    rd(3'd3, 32'h1060, "R4 enq held on overflow");
    rd(3'd1, 32'h30, "R4 overflow bit");
    chk({31'b0, irq_o}, 32'h1, "R10 irq on overflow");
    wr(3'd1, 32'h20);
    rd(3'd1, 32'h10, "R9 overflow cleared by W1C");
    chk({31'b0, irq_o}, 32'h0, "R10 irq drops");

    wr(3'd4, 32'h4);
    wr(3'd0, 32'h1);
    wait_idle();
    rd(3'd2, 32'h1060, "R7 deq after three completions");
    rd(3'd1, 32'h3, "R7 end of message set");
    wr(3'd1, 32'h2);
    rd(3'd1, 32'h1, "R9 eom cleared");

    repeat (2) wr(3'd0, 32'h3);
    wait_idle();
    rd(3'd3, 32'h1020, "R3 enq wrapped");
    rd(3'd2, 32'h1020, "R7 deq wrapped");

    wr(3'd0, 32'hF001);
    rd(3'd0, 32'h9001, "R2 size code saturates");
    wr(3'd0, 32'h0001);
    wr(3'd1, 32'h2);

    put_desc(1, 1'b0, 32'd128);
    err_arm = 1;
    wr(3'd0, 32'h3);
    wait_idle();
    rd(3'd1, 32'h80, "R8 transfer error flagged");
    rd(3'd0, 32'h0, "R8 enable cleared on error");
    rd(3'd2, 32'h1020, "R8 deq held on error");
    wr(3'd1, 32'h80);

    put_desc(1, 1'b0, 32'd24);
    saw_txv = 0;
    wr(3'd0, 32'h1);
    wait_idle();
    chk({31'b0, saw_txv}, 32'h0, "R8 bad size never sent");
    rd(3'd1, 32'h80, "R8 bad size error");
    rd(3'd2, 32'h1020, "R8 deq held on bad size");
    wr(3'd1, 32'h80);

    put_desc(1, 1'b0, 32'd256);
    wr(3'd0, 32'h2);
    wr(3'd0, 32'h1);
    wr(3'd3, 32'h1000);
    rd(3'd3, 32'h1060, "R12 enq write ignored while enabled");
    wr(3'd0, 32'h0);
    wait_idle();
    repeat (5) step();
    rd(3'd2, 32'h1040, "R11 one descriptor finished after disable");
    rd(3'd1, 32'h0, "R11 stopped with work pending");
    wr(3'd2, 32'h1060);
    rd(3'd1, 32'h1, "R12 deq write while disabled");
    repeat (3) step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule